// File: doc/BRIEF.md
# Resolver Converter Host Interface Sequencer

This block is the host-side controller for an external tracking resolver-to-digital converter. The converter sits on an SPI link. Its chip select is tied active, so every frame is bounded by one active-low frame-select line. A few discrete lines complete the link: an active-low converter reset, an active-low sample strobe, two mode-select lines and two resolution-select lines. The converter also drives two active-low fault lines back to the controller.

The host issues one command at a time over a valid/ready handshake. There are four commands. Position read and velocity read put the converter in normal mode, pulse the sample strobe, shift out 16 bits and mask the word to the requested resolution. Configuration write sends one 16-bit frame. Configuration read sends the address in one frame and collects the data byte in a second frame. Each command ends with a one-cycle result pulse.

Before every frame, the mode lines are set while the frame-select line is high and then left to settle. The two fault inputs are reported as a registered 2-bit code.

Top module: `rdc_host_seq`

## Requirements
- R1: While `rst_n` is low, and for `RST_CYC` clock edges after it rises, `conv_rst_n` and `cmd_ready` are low. During that time `conv_sample_n`, `spi_fs_n` and `rsp_valid` are at their idle levels, `conv_mode` is 00 and `conv_res` is 01 (12 bits). After the `RST_CYC`-th edge, `conv_rst_n` and `cmd_ready` go high.
- R2: `conv_mode` is set when a command is accepted: 00 for `cmd_op`=0 (position), 01 for `cmd_op`=1 (velocity), and 11 for `cmd_op`=2 (configuration write) or `cmd_op`=3 (configuration read). `conv_mode` never shows 10 and never changes while `spi_fs_n` is low.
- R3: Before any frame starts, `conv_mode` has held its current value, with `spi_fs_n` high, for at least `SETTLE_CYC` clock cycles.
- R4: A position or velocity read drives `conv_sample_n` low for `SAMPLE_CYC` cycles, and only while `spi_fs_n` is high. Only after that pulse does it run one 16-bit frame, MSB first, with `spi_mosi` held at 0.
- R5: A position or velocity read drives `conv_res` from `cmd_res`, taken at acceptance. The result is the received word with the bits below the resolution cleared. The resolution codes are 00 = 10 bits, 01 = 12 bits, 10 = 14 bits and 11 = 16 bits, where bit 15 is the MSB and the upper bits are kept.
- R6: A configuration write sends one 16-bit frame: bit 15 = 1, bits 14..8 = `cmd_addr`, bits 7..0 = `cmd_wdata`. It then returns `rsp_data` = 0.
- R7: A configuration read first sends an 8-bit frame: bit 7 = 0, bits 6..0 = `cmd_addr`. It then runs a second 8-bit frame with `spi_mosi` at 0 and returns the byte received there as `rsp_data`[7:0], with the upper byte 0.
- R8: A command is accepted on a clock edge where `cmd_valid` and `cmd_ready` are both high. `busy` is high, and `cmd_ready` low, from that edge through the cycle of the `rsp_valid` pulse. A command offered while busy waits and is accepted only once `cmd_ready` returns high.
- R9: `rsp_valid` is a one-cycle pulse that rises L edges after the accepting edge. With S = `SETTLE_CYC`, P = `SAMPLE_CYC` and H = `SCLK_HALF`, L is:
  - 2S+P+32H+1 for a position or velocity read;
  - S+32H+1 for a configuration write;
  - 2S+32H+2 for a configuration read.
- R10: `fault_code` is {not `flt_lot_n`, not `flt_dos_n`}, registered on each clock edge. It is 00 in reset.
- R11: `spi_sclk` is low whenever `spi_fs_n` is high. In a frame, the first rising edge of `spi_sclk` comes H cycles after `spi_fs_n` falls, and later rising edges come every 2H cycles. `spi_mosi` changes as `spi_sclk` falls, and `spi_miso` is sampled as it rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Controller can accept a command |
| cmd_op | input | 2 | 0 position, 1 velocity, 2 configuration write, 3 configuration read |
| cmd_addr | input | 7 | Configuration register address |
| cmd_wdata | input | 8 | Configuration write byte |
| cmd_res | input | 2 | Resolution code for normal reads |
| busy | output | 1 | Command in progress |
| rsp_valid | output | 1 | Result pulse |
| rsp_data | output | 16 | Result word |
| conv_rst_n | output | 1 | Converter reset, active low |
| conv_sample_n | output | 1 | Sample strobe, active low |
| conv_mode | output | 2 | Mode-select lines |
| conv_res | output | 2 | Resolution-select lines |
| spi_sclk | output | 1 | Serial clock |
| spi_fs_n | output | 1 | Frame select, active low |
| spi_mosi | output | 1 | Serial data to converter |
| spi_miso | input | 1 | Serial data from converter |
| flt_lot_n | input | 1 | Loss-of-tracking fault, active low |
| flt_dos_n | input | 1 | Degradation-of-signal fault, active low |
| fault_code | output | 2 | Registered fault code, 1 = fault |

## Verification
The reference model starts a countdown of the R9 latency at the edge where it sees a command accepted. It expects `rsp_valid` and the result in exactly the cycle where the count reaches zero, and expects `busy` to fall one edge later. `fault_code` is due one edge after its inputs change, and `conv_rst_n` and `cmd_ready` are due on the `RST_CYC`-th edge after reset. The bench drives inputs and samples outputs only at the falling clock edge, so every comparison lands on settled registered values. The frame content, the settling time and the SCLK spacing are checked by a converter model that reacts to the serial and strobe lines themselves.

// File: rtl/rdc_pkg.sv
`timescale 1ns/1ps
package rdc_pkg;

    localparam int WORD_W = 16;
    localparam int ADDR_W = 7;
    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        OP_POS = 2'd0,
        OP_VEL = 2'd1,
        OP_WR  = 2'd2,
        OP_RD  = 2'd3
    } op_e;

    typedef enum logic [2:0] {
        ST_RESET,
        ST_IDLE,
        ST_SETTLE,
        ST_STROBE,
        ST_FRAME,
        ST_DONE
    } st_e;

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

    // keep the top 10+2*code bits of a word, clear the rest
    function automatic logic [WORD_W-1:0] res_mask(input logic [1:0] code);
        int drop;
        drop = 6 - 2 * int'(code);
        return {WORD_W{1'b1}} << drop;
    endfunction

endpackage

// File: rtl/rdc_wait_timer.sv
`timescale 1ns/1ps
module rdc_wait_timer #(
    parameter int TW      = 3,
    parameter int RST_VAL = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [TW-1:0] load_val,
    output logic          zero
);
    logic [TW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - TW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= TW'(RST_VAL);
        else        cnt_q <= cnt_d;
    end

    assign zero = (cnt_q == '0);

    AST_TIMER_LOAD_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (cnt_q == $past(load_val))) else $error("timer load"); // R9
endmodule

// File: rtl/rdc_spi_frame.sv
`timescale 1ns/1ps
module rdc_spi_frame
    import rdc_pkg::*;
#(
    parameter int SCLK_HALF = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              len16,
    input  logic [WORD_W-1:0] tx,
    input  logic              miso,
    output logic              sclk,
    output logic              fs_n,
    output logic              mosi,
    output logic              done,
    output logic [WORD_W-1:0] rx
);
    localparam int CW = (SCLK_HALF > 1) ? $clog2(SCLK_HALF) : 1;
    localparam int BW = $clog2(WORD_W);

    typedef struct packed {
        logic              active;
        logic              sclk;
        logic              fs_n;
        logic              done;
        logic [CW-1:0]     cnt;
        logic [BW-1:0]     bitn;
        logic [BW-1:0]     last;
        logic [WORD_W-1:0] sh;
        logic [WORD_W-1:0] rx;
    } eng_t;

    eng_t eng_d, eng_q;

    always_comb begin
        eng_d      = eng_q;
        eng_d.done = 1'b0;
        if (!eng_q.active) begin
            if (start) begin
                eng_d.active = 1'b1;
                eng_d.fs_n   = 1'b0;
                eng_d.sclk   = 1'b0;
                eng_d.cnt    = '0;
                eng_d.bitn   = '0;
                eng_d.last   = len16 ? BW'(WORD_W - 1) : BW'(BYTE_W - 1);
                eng_d.sh     = tx;
            end
        end else if (eng_q.cnt == CW'(SCLK_HALF - 1)) begin
            eng_d.cnt = '0;
            if (!eng_q.sclk) begin
                eng_d.sclk = 1'b1;
                eng_d.rx   = {eng_q.rx[WORD_W-2:0], miso};
            end else begin
                eng_d.sclk = 1'b0;
                if (eng_q.bitn == eng_q.last) begin
                    eng_d.active = 1'b0;
                    eng_d.fs_n   = 1'b1;
                    eng_d.done   = 1'b1;
                end else begin
                    eng_d.bitn = eng_q.bitn + BW'(1);
                    eng_d.sh   = {eng_q.sh[WORD_W-2:0], 1'b0};
                end
            end
        end else begin
            eng_d.cnt = eng_q.cnt + CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            eng_q      <= '0;
            eng_q.fs_n <= 1'b1;
        end else begin
            eng_q <= eng_d;
        end
    end

    assign sclk = eng_q.sclk;
    assign fs_n = eng_q.fs_n;
    assign mosi = eng_q.active & eng_q.sh[WORD_W-1];
    assign done = eng_q.done;
    assign rx   = eng_q.rx;

    AST_SCLK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        fs_n |-> !sclk) else $error("sclk moved outside frame"); // R11
    AST_MOSI_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        (!fs_n && $past(!fs_n) && !$fell(sclk)) |-> $stable(mosi)) else $error("mosi moved off falling sclk"); // R11
endmodule

// File: rtl/rdc_host_seq.sv
`timescale 1ns/1ps
module rdc_host_seq
    import rdc_pkg::*;
#(
    parameter int SCLK_HALF  = 2,
    parameter int SETTLE_CYC = 3,
    parameter int SAMPLE_CYC = 2,
    parameter int RST_CYC    = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cmd_valid,
    output logic        cmd_ready,
    input  logic [1:0]  cmd_op,
    input  logic [6:0]  cmd_addr,
    input  logic [7:0]  cmd_wdata,
    input  logic [1:0]  cmd_res,
    output logic        busy,
    output logic        rsp_valid,
    output logic [15:0] rsp_data,
    output logic        conv_rst_n,
    output logic        conv_sample_n,
    output logic [1:0]  conv_mode,
    output logic [1:0]  conv_res,
    output logic        spi_sclk,
    output logic        spi_fs_n,
    output logic        spi_mosi,
    input  logic        spi_miso,
    input  logic        flt_lot_n,
    input  logic        flt_dos_n,
    output logic [1:0]  fault_code
);
    localparam int MAXC = max3(RST_CYC, SETTLE_CYC, SAMPLE_CYC);
    localparam int TW   = $clog2(MAXC + 1);

    typedef struct packed {
        st_e               st;
        op_e               op;
        logic [ADDR_W-1:0] addr;
        logic [BYTE_W-1:0] wdata;
        logic [1:0]        res;
        logic [1:0]        mode;
        logic [1:0]        respin;
        logic              sampled;
        logic              rd_phase;
        logic              rsp_valid;
        logic [WORD_W-1:0] rdata;
        logic [1:0]        fault;
    } seq_t;

    seq_t seq_d, seq_q;

    logic              tmr_load, tmr_zero;
    logic [TW-1:0]     tmr_val;
    logic              spi_start, spi_len16, spi_done;
    logic [WORD_W-1:0] spi_tx, spi_rx;
    logic              is_normal;

    assign is_normal = (seq_q.op == OP_POS) || (seq_q.op == OP_VEL);

    rdc_wait_timer #(.TW(TW), .RST_VAL(RST_CYC - 1)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .zero     (tmr_zero)
    );

    rdc_spi_frame #(.SCLK_HALF(SCLK_HALF)) u_frame (
        .clk   (clk),
        .rst_n (rst_n),
        .start (spi_start),
        .len16 (spi_len16),
        .tx    (spi_tx),
        .miso  (spi_miso),
        .sclk  (spi_sclk),
        .fs_n  (spi_fs_n),
        .mosi  (spi_mosi),
        .done  (spi_done),
        .rx    (spi_rx)
    );

    always_comb begin
        seq_d           = seq_q;
        seq_d.rsp_valid = 1'b0;
        seq_d.fault     = {~flt_lot_n, ~flt_dos_n};
        tmr_load        = 1'b0;
        tmr_val         = '0;
        spi_start       = 1'b0;
        spi_len16       = 1'b1;
        spi_tx          = '0;
        unique case (seq_q.st)
            ST_RESET: begin
                if (tmr_zero) seq_d.st = ST_IDLE;
            end
            ST_IDLE: begin
                if (cmd_valid) begin
                    seq_d.op       = op_e'(cmd_op);
                    seq_d.addr     = cmd_addr;
                    seq_d.wdata    = cmd_wdata;
                    seq_d.res      = cmd_res;
                    seq_d.sampled  = 1'b0;
                    seq_d.rd_phase = 1'b0;
                    unique case (op_e'(cmd_op))
                        OP_POS:  seq_d.mode = 2'b00;
                        OP_VEL:  seq_d.mode = 2'b01;
                        default: seq_d.mode = 2'b11;
                    endcase
                    if (!cmd_op[1]) seq_d.respin = cmd_res;
                    seq_d.st = ST_SETTLE;
                    tmr_load = 1'b1;
                    tmr_val  = TW'(SETTLE_CYC - 1);
                end
            end
            ST_SETTLE: begin
                if (tmr_zero) begin
                    if (is_normal && !seq_q.sampled) begin
                        seq_d.st = ST_STROBE;
                        tmr_load = 1'b1;
                        tmr_val  = TW'(SAMPLE_CYC - 1);
                    end else begin
                        seq_d.st  = ST_FRAME;
                        spi_start = 1'b1;
                        spi_len16 = (seq_q.op != OP_RD);
                        if (seq_q.op == OP_WR)
                            spi_tx = {1'b1, seq_q.addr, seq_q.wdata};
                        else if (seq_q.op == OP_RD && !seq_q.rd_phase)
                            spi_tx = {1'b0, seq_q.addr, {BYTE_W{1'b0}}};
                    end
                end
            end
            ST_STROBE: begin
                if (tmr_zero) begin
                    seq_d.sampled = 1'b1;
                    seq_d.st      = ST_SETTLE;
                    tmr_load      = 1'b1;
                    tmr_val       = TW'(SETTLE_CYC - 1);
                end
            end
            ST_FRAME: begin
                if (spi_done) begin
                    if (seq_q.op == OP_RD && !seq_q.rd_phase) begin
                        seq_d.rd_phase = 1'b1;
                        seq_d.st       = ST_SETTLE;
                        tmr_load       = 1'b1;
                        tmr_val        = TW'(SETTLE_CYC - 1);
                    end else begin
                        if (is_normal)
                            seq_d.rdata = spi_rx & res_mask(seq_q.res);
                        else if (seq_q.op == OP_RD)
                            seq_d.rdata = {{BYTE_W{1'b0}}, spi_rx[BYTE_W-1:0]};
                        else
                            seq_d.rdata = '0;
                        seq_d.rsp_valid = 1'b1;
                        seq_d.st        = ST_DONE;
                    end
                end
            end
            ST_DONE: begin
                seq_d.st = ST_IDLE;
            end
            default: seq_d.st = ST_RESET;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q        <= '0;
            seq_q.st     <= ST_RESET;
            seq_q.op     <= OP_POS;
            seq_q.respin <= 2'b01;
            seq_q.res    <= 2'b01;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign cmd_ready     = (seq_q.st == ST_IDLE);
    assign busy          = (seq_q.st != ST_IDLE) && (seq_q.st != ST_RESET);
    assign rsp_valid     = seq_q.rsp_valid;
    assign rsp_data      = seq_q.rdata;
    assign conv_rst_n    = (seq_q.st != ST_RESET);
    assign conv_sample_n = (seq_q.st != ST_STROBE);
    assign conv_mode     = seq_q.mode;
    assign conv_res      = seq_q.respin;
    assign fault_code    = seq_q.fault;

    // settling watch: cycles the mode lines have held with frame select high
    logic [TW-1:0] quiet_d, quiet_q;
    logic [1:0]    mode_prev_q;

    always_comb begin
        quiet_d = quiet_q;
        if (!spi_fs_n || conv_mode != mode_prev_q) quiet_d = '0;
        else if (int'(quiet_q) < SETTLE_CYC) quiet_d = quiet_q + TW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            quiet_q     <= '0;
            mode_prev_q <= 2'b00;
        end else begin
            quiet_q     <= quiet_d;
            mode_prev_q <= conv_mode;
        end
    end

    AST_NO_RESERVED_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        conv_mode != 2'b10) else $error("reserved mode driven"); // R2
    AST_MODE_HELD_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        (!spi_fs_n && $past(!spi_fs_n)) |-> $stable(conv_mode)) else $error("mode moved in frame"); // R2
    AST_FRAME_SETTLED: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(spi_fs_n) |-> (int'(quiet_q) >= SETTLE_CYC - 1)) else $error("frame before settle"); // R3
    AST_SAMPLE_OUTSIDE_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        !conv_sample_n |-> spi_fs_n) else $error("strobe inside frame"); // R4
    AST_RSP_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (busy && !cmd_ready)) else $error("result outside command"); // R8
    AST_RSP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid) else $error("result pulse too long"); // R9
endmodule

// File: tb/sim_rdc_host_seq.sv
`timescale 1ns/1ps
module sim_rdc_host_seq;
    localparam int H = 2;
    localparam int S = 3;
    localparam int P = 2;
    localparam int R = 4;
    localparam int TCK = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic        cmd_ready;
    logic [1:0]  cmd_op = 2'd0;
    logic [6:0]  cmd_addr = 7'd0;
    logic [7:0]  cmd_wdata = 8'd0;
    logic [1:0]  cmd_res = 2'd1;
    logic        busy, rsp_valid;
    logic [15:0] rsp_data;
    logic        conv_rst_n, conv_sample_n;
    logic [1:0]  conv_mode, conv_res;
    logic        spi_sclk, spi_fs_n, spi_mosi;
    logic        spi_miso = 1'b0;
    logic        flt_lot_n = 1'b1, flt_dos_n = 1'b1;
    logic [1:0]  fault_code;

    always #(TCK/2) clk = ~clk;

    rdc_host_seq #(.SCLK_HALF(H), .SETTLE_CYC(S), .SAMPLE_CYC(P), .RST_CYC(R)) u0 (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .cmd_res(cmd_res),
        .busy(busy), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .conv_rst_n(conv_rst_n), .conv_sample_n(conv_sample_n),
        .conv_mode(conv_mode), .conv_res(conv_res),
        .spi_sclk(spi_sclk), .spi_fs_n(spi_fs_n), .spi_mosi(spi_mosi), .spi_miso(spi_miso),
        .flt_lot_n(flt_lot_n), .flt_dos_n(flt_dos_n), .fault_code(fault_code)
    );

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    function automatic logic [15:0] keep_mask(input logic [1:0] code);
        int keep;
        logic [15:0] m;
        keep = 10 + 2 * int'(code);
        for (int i = 0; i < 16; i++) m[i] = (i >= 16 - keep);
        return m;
    endfunction

    function automatic int latency(input logic [1:0] op);
        if (op == 2'd2) return S + 32*H + 1;
        if (op == 2'd3) return 2*S + 32*H + 2;
        return 2*S + P + 32*H + 1;
    endfunction

    // converter-side state
    logic [15:0] pos_val = 16'h0000, vel_val = 16'h0000;
    logic [15:0] lat_pos = 16'h0000, lat_vel = 16'h0000;
    logic [7:0]  sregs [128];
    logic [7:0]  eregs [128];

    // reference model
    int          m_rcnt = 0;
    bit          m_busy = 0;
    int          m_rem = 0;
    logic [15:0] m_exp = 16'h0;
    string       m_tag = "R5";
    logic [1:0]  m_fault = 2'b00;
    logic [1:0]  cur_op = 2'd0;
    logic [1:0]  cur_res = 2'd1;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_rcnt = 0; m_busy = 0; m_rem = 0; m_fault = 2'b00;
        end else begin
            bit was_ready;
            was_ready = (m_rcnt >= R) && !m_busy;
            if (m_rcnt < R) m_rcnt++;
            m_fault = {~flt_lot_n, ~flt_dos_n};
            if (m_busy) begin
                if (m_rem == 0) m_busy = 0;
                else m_rem--;
            end else if (was_ready && cmd_valid) begin
                m_busy  = 1;
                m_rem   = latency(cmd_op);
                cur_op  = cmd_op;
                cur_res = (cmd_op[1]) ? cur_res : cmd_res;
                case (cmd_op)
                    2'd0: begin m_exp = pos_val & keep_mask(cmd_res); m_tag = "R5 position"; end
                    2'd1: begin m_exp = vel_val & keep_mask(cmd_res); m_tag = "R5 velocity"; end
                    2'd2: begin m_exp = 16'h0; m_tag = "R6 write result"; eregs[cmd_addr] = cmd_wdata; end
                    default: begin m_exp = {8'h00, eregs[cmd_addr]}; m_tag = "R7 read result"; end
                endcase
            end
        end
    end

    // every-clock comparison
    always @(negedge clk) begin
        if (!finished) begin
            chk("R1 conv_rst_n", conv_rst_n, (m_rcnt >= R));
            chk("R8 cmd_ready", cmd_ready, (m_rcnt >= R) && !m_busy);
            chk("R8 busy", busy, m_busy);
            chk("R9 rsp_valid", rsp_valid, m_busy && (m_rem == 0));
            chk("R10 fault_code", fault_code, m_fault);
            chk("R2 no reserved mode", (conv_mode == 2'b10), 1'b0);
            if (m_busy && m_rem == 0) chk(m_tag, rsp_data, m_exp);
        end
    end

    // settling count seen by the bench
    int         quiet = 0;
    logic [1:0] prev_mode = 2'b00;
    always @(posedge clk) begin
        if (!rst_n) quiet = 0;
        else if (spi_fs_n && conv_mode == prev_mode) quiet++;
        else quiet = 0;
        prev_mode = conv_mode;
    end

    // converter model on the serial and strobe lines
    logic [15:0] s_out = 16'h0, s_rx = 16'h0;
    int          s_bits = 0;
    logic [1:0]  s_mode = 2'b00;
    bit          s_inframe = 0, s_sampled = 0, s_pend = 0;
    logic [6:0]  s_paddr = 7'd0;
    longint      t_rise = 0;

    always @(negedge conv_sample_n) begin
        if (rst_n) begin
            lat_pos = pos_val; lat_vel = vel_val; s_sampled = 1;
        end
    end

    always @(negedge spi_fs_n) begin
        if (rst_n) begin
            s_inframe = 1; s_bits = 0; s_rx = 16'h0; s_mode = conv_mode;
            t_rise = $time;
            case (conv_mode)
                2'b00: s_out = lat_pos;
                2'b01: s_out = lat_vel;
                default: s_out = s_pend ? {sregs[s_paddr], 8'h00} : 16'h0;
            endcase
            spi_miso = s_out[15];
            chk("R2 mode at frame", conv_mode, (cur_op == 2'd0) ? 2'b00 : (cur_op == 2'd1) ? 2'b01 : 2'b11);
            chk("R3 settle", (quiet >= S - 1), 1'b1);
            chk("R11 sclk low at frame start", spi_sclk, 1'b0);
            if (!conv_mode[1]) begin
                chk("R4 strobe before frame", s_sampled, 1'b1);
                chk("R5 resolution pins", conv_res, cur_res);
                s_sampled = 0;
            end
        end
    end

    always @(posedge spi_sclk) begin
        if (s_inframe) begin
            chk("R11 sclk spacing", $time - t_rise, (s_bits == 0) ? H*TCK : 2*H*TCK);
            t_rise = $time;
            s_rx = {s_rx[14:0], spi_mosi};
            s_bits++;
        end
    end

    always @(negedge spi_sclk) begin
        if (s_inframe && s_bits < 16) spi_miso = s_out[15 - s_bits];
    end

    always @(posedge spi_fs_n) begin
        if (s_inframe) begin
            s_inframe = 0;
            if (s_mode == 2'b11) begin
                if (s_bits == 16) begin
                    chk("R6 write flag", s_rx[15], 1'b1);
                    sregs[s_rx[14:8]] = s_rx[7:0];
                    s_pend = 0;
                end else if (s_bits == 8 && !s_pend) begin
                    chk("R7 address flag", s_rx[7], 1'b0);
                    s_pend = 1; s_paddr = s_rx[6:0];
                end else if (s_bits == 8) begin
                    chk("R7 data frame mosi", s_rx[7:0], 8'h00);
                    s_pend = 0;
                end else begin
                    chk("R6 R7 frame length", s_bits, 16);
                end
            end else begin
                chk("R4 frame length", s_bits, 16);
                chk("R4 mosi idle", s_rx, 16'h0);
            end
        end
    end

    task automatic run_cmd(input logic [1:0] op, input logic [6:0] a, input logic [7:0] d,
                           input logic [1:0] res, input bit wait_rsp);
        @(negedge clk);
        cmd_op = op; cmd_addr = a; cmd_wdata = d; cmd_res = res; cmd_valid = 1'b1;
        while (cmd_ready !== 1'b1) @(negedge clk);
        @(negedge clk);
        cmd_valid = 1'b0;
        if (wait_rsp) begin
            while (rsp_valid !== 1'b1) @(negedge clk);
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        for (int i = 0; i < 128; i++) begin
            sregs[i] = 8'(i) ^ 8'h5A;
            eregs[i] = 8'(i) ^ 8'h5A;
        end
        repeat (2) @(negedge clk);
        // R1 idle levels during reset
        chk("R1 sample idle", conv_sample_n, 1'b1);
        chk("R1 fs idle", spi_fs_n, 1'b1);
        chk("R1 sclk idle", spi_sclk, 1'b0);
        chk("R1 mode reset", conv_mode, 2'b00);
        chk("R1 res reset 12 bit", conv_res, 2'b01);
        chk("R1 no result", rsp_valid, 1'b0);
        rst_n = 1'b1;
        while (cmd_ready !== 1'b1) @(negedge clk);

        pos_val = 16'hBEEF;
        run_cmd(2'd0, 7'd0, 8'd0, 2'b11, 1);   // R5 16 bit
        run_cmd(2'd0, 7'd0, 8'd0, 2'b00, 1);   // R5 10 bit
        pos_val = 16'hFFFF;
        run_cmd(2'd0, 7'd0, 8'd0, 2'b01, 1);   // R5 12 bit
        run_cmd(2'd0, 7'd0, 8'd0, 2'b10, 1);   // R5 14 bit
        vel_val = 16'h1234;
        run_cmd(2'd1, 7'd0, 8'd0, 2'b00, 1);   // R5 velocity
        vel_val = 16'hA5C3;
        run_cmd(2'd1, 7'd0, 8'd0, 2'b11, 1);

        run_cmd(2'd2, 7'h11, 8'hC3, 2'b00, 1); // R6 write
        run_cmd(2'd3, 7'h11, 8'h00, 2'b00, 1); // R7 read back
        run_cmd(2'd3, 7'h22, 8'h00, 2'b00, 1); // R7 untouched register
        run_cmd(2'd2, 7'h7F, 8'h00, 2'b00, 1);
        run_cmd(2'd3, 7'h7F, 8'h00, 2'b00, 1);
        run_cmd(2'd2, 7'h00, 8'hFF, 2'b00, 1);
        run_cmd(2'd3, 7'h00, 8'h00, 2'b00, 1);

        // R8 a command offered while busy waits for ready
        pos_val = 16'h8001;
        vel_val = 16'h7FFE;
        run_cmd(2'd0, 7'd0, 8'd0, 2'b11, 0);
        repeat (5) @(negedge clk);
        run_cmd(2'd1, 7'd0, 8'd0, 2'b10, 1);
        run_cmd(2'd2, 7'h05, 8'h3C, 2'b00, 0);
        run_cmd(2'd3, 7'h05, 8'h00, 2'b00, 1);

        // R10 fault patterns
        @(negedge clk); flt_lot_n = 1'b0;
        repeat (3) @(negedge clk); flt_dos_n = 1'b0;
        repeat (3) @(negedge clk); flt_lot_n = 1'b1;
        repeat (3) @(negedge clk); flt_dos_n = 1'b1;
        repeat (3) @(negedge clk);

        finish_run();
    end
endmodule